// File: doc/BRIEF.md
# Block-Scaled FP4 Dot-Product Accumulator

This unit takes two operand blocks per cycle and adds their dot product into a running sum. Each operand block has sixteen 4-bit floating-point codes and one 8-bit floating-point scale. The 4-bit codes are multiplied as they are: the two small significands are multiplied and the two exponents are added, so no element is first widened into a general number format. The sixteen exact products are summed. That sum is multiplied by the exact product of the two block scales, and the scaled result goes into a wide signed fixed-point accumulator.

A long dot product is built by streaming block pairs, one per cycle. The first pair of a new dot product is marked with the clear control, which loads the accumulator instead of adding to it. The accumulator saturates instead of wrapping, and two sticky flags report saturation and invalid scale codes. Per-tensor scaling and conversion of the result to a standard float are done outside this unit.

Top module: `fp4_block_dot`

## Requirements
- R1: An element code has a sign in bit 3, a 2-bit exponent in bits 2:1 and a mantissa in bit 0. Its magnitude follows the exponent: 00 gives 0 or 0.5, 01 gives 1 or 1.5, 10 gives 2 or 3, and 11 gives 4 or 6. Element i of an operand sits in bits 4i+3:4i. A negative-zero code (1000) adds nothing.
- R2: A scale byte has a sign in bit 7, a 4-bit exponent with bias 7 in bits 6:3 and a mantissa in bits 2:0. An exponent of 0 gives the subnormal value m·2^-9. Any other exponent e gives (1+m/8)·2^(e-7). A block's term is the exact sum of its sixteen element products times both scale values.
- R3: `acc_out` is a 48-bit two's-complement value with 20 fractional bits. Each accepted block pair without clear adds its term to it exactly.
- R4: A pair sampled at rising edge k updates `acc_out` at edge k+2, and `out_valid` is high for exactly the cycle after that edge. A new pair is accepted every cycle.
- R5: When `acc_clear` is high together with `in_valid`, the pair's term replaces the accumulator. When `acc_clear` is high without `in_valid`, nothing changes.
- R6: A sum above 2^47-1 or below -2^47 is clamped to that limit, and `overflow` is set. `overflow` then stays set through later additions.
- R7: The scale code with exponent 1111 and mantissa 111 is invalid. A block with such a scale contributes zero, and `invalid` is set and stays set.
- R8: A clear-load sets `overflow` and `invalid` from that block alone, which clears any earlier flag.
- R9: After reset, `acc_out` is 0 and `out_valid`, `overflow` and `invalid` are low.
- R10: `acc_out` and the flags hold their values in every cycle that has no update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | A block pair is present this cycle |
| acc_clear | input | 1 | With `in_valid`: load the accumulator instead of adding |
| a_codes | input | 64 | Sixteen 4-bit element codes of operand A |
| b_codes | input | 64 | Sixteen 4-bit element codes of operand B |
| a_scale | input | 8 | 8-bit float scale of block A |
| b_scale | input | 8 | 8-bit float scale of block B |
| acc_out | output | 48 | Signed accumulator, 20 fractional bits |
| out_valid | output | 1 | `acc_out` was updated at the last edge |
| overflow | output | 1 | Sticky saturation flag |
| invalid | output | 1 | Sticky invalid-scale flag |

## Verification
The assertions assume that `in_valid` stays low from reset assertion until two edges after `rst_n` rises, because the reset synchronizer holds the pipeline during that time. The latency property would not hold for a pair offered earlier. The bench waits three edges after release before it drives anything, and it changes inputs only 2 ns after an edge. The saturation property also assumes that the accumulator can only be at a limit after a clamp, which is true for every term the bench drives.

// File: rtl/fp4dot_pkg.sv
package fp4dot_pkg;

  localparam int ELEM_W      = 4;
  localparam int SCALE_W     = 8;
  localparam int SC_EXP_W    = 4;
  localparam int SC_MAN_W    = 3;
  localparam int SSIG_W      = SC_MAN_W + 1;
  localparam int SSH_W       = SC_EXP_W;
  localparam int MAX_SSH     = (1 << SC_EXP_W) - 2;
  // element product in quarters: magnitude up to 144, plus sign
  localparam int PROD_W      = 9;
  localparam int FRAC_W      = 20;

  typedef struct packed {
    logic [SSIG_W-1:0] sig;
    logic [SSH_W-1:0]  sh;
    logic              neg;
    logic              nan;
  } scale_dec_t;

endpackage

// File: rtl/fp4dot_rst_sync.sv
module fp4dot_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_n_sync <= stage_q;
    end
  end

endmodule

// File: rtl/fp4dot_e2m1_mul.sv
module fp4dot_e2m1_mul
  import fp4dot_pkg::*;
(
  input  logic [ELEM_W-1:0]        a_code,
  input  logic [ELEM_W-1:0]        b_code,
  output logic signed [PROD_W-1:0] prod
);

  logic [1:0] a_sig, b_sig;
  logic [1:0] a_sh, b_sh;
  logic [3:0] sig_prod;
  logic [2:0] sh_sum;
  logic [7:0] mag;

  always_comb begin
    // significand in halves: hidden bit present when exponent is non-zero
    a_sig    = {|a_code[2:1], a_code[0]};
    b_sig    = {|b_code[2:1], b_code[0]};
    a_sh     = (a_code[2:1] == 2'd0) ? 2'd0 : a_code[2:1] - 2'd1;
    b_sh     = (b_code[2:1] == 2'd0) ? 2'd0 : b_code[2:1] - 2'd1;
    sig_prod = {2'b00, a_sig} * {2'b00, b_sig};
    sh_sum   = {1'b0, a_sh} + {1'b0, b_sh};
    mag      = {4'b0000, sig_prod} << sh_sum;
    // a zero magnitude yields zero whatever the sign bits are
    prod     = (a_code[3] ^ b_code[3]) ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
  end

endmodule

// File: rtl/fp4dot_e4m3_dec.sv
module fp4dot_e4m3_dec
  import fp4dot_pkg::*;
(
  input  logic [SCALE_W-1:0] code,
  output scale_dec_t         dec
);

  logic [SC_EXP_W-1:0] exp_f;
  logic [SC_MAN_W-1:0] man_f;

  always_comb begin
    exp_f   = code[SCALE_W-2 -: SC_EXP_W];
    man_f   = code[SC_MAN_W-1:0];
    dec.neg = code[SCALE_W-1];
    dec.nan = &code[SCALE_W-2:0];
    // value = sig << sh, in units of 2^-9
    if (exp_f == '0) begin
      dec.sig = {1'b0, man_f};
      dec.sh  = '0;
    end else begin
      dec.sig = {1'b1, man_f};
      dec.sh  = exp_f - SC_EXP_W'(1);
    end
  end

endmodule

// File: rtl/fp4dot_acc_sat.sv
module fp4dot_acc_sat #(
  parameter int ACC_W  = 48,
  parameter int TERM_W = 50
) (
  input  logic signed [ACC_W-1:0]  acc_q,
  input  logic signed [TERM_W-1:0] term,
  input  logic                     load,
  output logic signed [ACC_W-1:0]  acc_d,
  output logic                     sat
);

  localparam int WIDE_W = ((TERM_W > ACC_W) ? TERM_W : ACC_W) + 1;

  logic signed [WIDE_W-1:0] base, total, max_v, min_v;

  always_comb begin
    base  = load ? '0 : {{(WIDE_W-ACC_W){acc_q[ACC_W-1]}}, acc_q};
    total = base + {{(WIDE_W-TERM_W){term[TERM_W-1]}}, term};
    max_v = {{(WIDE_W-ACC_W+1){1'b0}}, {(ACC_W-1){1'b1}}};
    min_v = {{(WIDE_W-ACC_W+1){1'b1}}, {(ACC_W-1){1'b0}}};
    if (total > max_v) begin
      acc_d = {1'b0, {(ACC_W-1){1'b1}}};
      sat   = 1'b1;
    end else if (total < min_v) begin
      acc_d = {1'b1, {(ACC_W-1){1'b0}}};
      sat   = 1'b1;
    end else begin
      acc_d = total[ACC_W-1:0];
      sat   = 1'b0;
    end
  end

endmodule

// File: rtl/fp4_block_dot.sv
module fp4_block_dot
  import fp4dot_pkg::*;
#(
  parameter int N_ELEM = 16,
  parameter int ACC_W  = 48
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic                     acc_clear,
  input  logic [N_ELEM*ELEM_W-1:0] a_codes,
  input  logic [N_ELEM*ELEM_W-1:0] b_codes,
  input  logic [SCALE_W-1:0]       a_scale,
  input  logic [SCALE_W-1:0]       b_scale,
  output logic signed [ACC_W-1:0]  acc_out,
  output logic                     out_valid,
  output logic                     overflow,
  output logic                     invalid
);

  localparam int SUM_W   = PROD_W + $clog2(N_ELEM);
  localparam int SPROD_W = 2 * SSIG_W;
  localparam int SSUM_W  = SSH_W + 1;
  localparam int MUL_W   = SUM_W + SPROD_W + 1;
  localparam int TERM_W  = MUL_W + 2 * MAX_SSH;

  logic rst_sn;

  fp4dot_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_sn)
  );

  // ---------------- stage 1: element products, scale decode
  logic signed [PROD_W-1:0] prod_c [N_ELEM];
  scale_dec_t               sa_c, sb_c;

  for (genvar gi = 0; gi < N_ELEM; gi++) begin : g_lane
    fp4dot_e2m1_mul u_mul (
      .a_code (a_codes[gi*ELEM_W +: ELEM_W]),
      .b_code (b_codes[gi*ELEM_W +: ELEM_W]),
      .prod   (prod_c[gi])
    );
  end

  fp4dot_e4m3_dec u_dec_a (.code(a_scale), .dec(sa_c));
  fp4dot_e4m3_dec u_dec_b (.code(b_scale), .dec(sb_c));

  logic                     s1_vld, s1_clr;
  logic signed [PROD_W-1:0] s1_prod [N_ELEM];
  scale_dec_t               s1_sa, s1_sb;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) s1_vld <= 1'b0;
    else         s1_vld <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      s1_clr <= acc_clear;
      s1_sa  <= sa_c;
      s1_sb  <= sb_c;
      for (int i = 0; i < N_ELEM; i++) s1_prod[i] <= prod_c[i];
    end
  end

  // ---------------- stage 2: block sum, scale product
  logic signed [SUM_W-1:0]  sum_c;
  logic [SPROD_W-1:0]       ssig_c;
  logic [SSUM_W-1:0]        ssh_c;
  logic                     sneg_c, snan_c;

  always_comb begin
    sum_c = '0;
    for (int i = 0; i < N_ELEM; i++)
      sum_c = sum_c + {{(SUM_W-PROD_W){s1_prod[i][PROD_W-1]}}, s1_prod[i]};
    ssig_c = {{SSIG_W{1'b0}}, s1_sa.sig} * {{SSIG_W{1'b0}}, s1_sb.sig};
    ssh_c  = {1'b0, s1_sa.sh} + {1'b0, s1_sb.sh};
    sneg_c = s1_sa.neg ^ s1_sb.neg;
    snan_c = s1_sa.nan | s1_sb.nan;
  end

  logic                    s2_vld, s2_clr, s2_neg, s2_nan;
  logic signed [SUM_W-1:0] s2_sum;
  logic [SPROD_W-1:0]      s2_ssig;
  logic [SSUM_W-1:0]       s2_ssh;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) s2_vld <= 1'b0;
    else         s2_vld <= s1_vld;
  end

  always_ff @(posedge clk) begin
    if (s1_vld) begin
      s2_clr  <= s1_clr;
      s2_sum  <= sum_c;
      s2_ssig <= ssig_c;
      s2_ssh  <= ssh_c;
      s2_neg  <= sneg_c;
      s2_nan  <= snan_c;
    end
  end

  // ---------------- stage 3: scale, accumulate, saturate
  logic signed [MUL_W-1:0]  mul_c;
  logic signed [TERM_W-1:0] ext_c, shifted_c, term_c;
  logic signed [ACC_W-1:0]  acc_d;
  logic                     sat_c, ovf_d, inv_d;

  always_comb begin
    mul_c     = s2_sum * $signed({1'b0, s2_ssig});
    ext_c     = {{(TERM_W-MUL_W){mul_c[MUL_W-1]}}, mul_c};
    shifted_c = ext_c <<< s2_ssh;
    if (s2_nan)      term_c = '0;
    else if (s2_neg) term_c = -shifted_c;
    else             term_c = shifted_c;
  end

  fp4dot_acc_sat #(
    .ACC_W  (ACC_W),
    .TERM_W (TERM_W)
  ) u_acc_sat (
    .acc_q (acc_out),
    .term  (term_c),
    .load  (s2_clr),
    .acc_d (acc_d),
    .sat   (sat_c)
  );

  always_comb begin
    ovf_d = s2_clr ? sat_c  : (overflow | sat_c);
    inv_d = s2_clr ? s2_nan : (invalid | s2_nan);
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      acc_out   <= '0;
      out_valid <= 1'b0;
      overflow  <= 1'b0;
      invalid   <= 1'b0;
    end else begin
      out_valid <= s2_vld;
      if (s2_vld) begin
        acc_out  <= acc_d;
        overflow <= ovf_d;
        invalid  <= inv_d;
      end
    end
  end

endmodule

// File: rtl/fp4_block_dot_chk.sv
module fp4_block_dot_chk #(
  parameter int ACC_W = 48
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic signed [ACC_W-1:0] acc_out,
  input logic                    out_valid,
  input logic                    overflow,
  input logic                    invalid
);

  localparam logic signed [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

  // R4: every accepted pair shows up three edges later
  a_r4_fixed_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##3 out_valid);

  // R10: no movement of the result without an update
  a_r10_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(acc_out));

  // R6: a new overflow always leaves the accumulator at a rail
  a_r6_rail_on_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> (acc_out == ACC_MAX || acc_out == ACC_MIN));

  // R7: invalid only rises with an update
  a_r7_invalid_on_update: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(invalid) |-> out_valid);

  // R8: sticky flags only fall on an update (a clear-load)
  a_r8_flags_fall_on_update: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(overflow) || $fell(invalid)) |-> out_valid);

endmodule

bind fp4_block_dot fp4_block_dot_chk #(.ACC_W(ACC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .acc_out   (acc_out),
  .out_valid (out_valid),
  .overflow  (overflow),
  .invalid   (invalid)
);

// File: tb/test_fp4_block_dot.sv
module test_fp4_block_dot;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               in_valid, acc_clear;
  logic [63:0]        a_codes, b_codes;
  logic [7:0]         a_scale, b_scale;
  logic signed [47:0] acc_out;
  logic               out_valid, overflow, invalid;

  fp4_block_dot i_fp4_block_dot (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .acc_clear(acc_clear),
    .a_codes(a_codes), .b_codes(b_codes), .a_scale(a_scale), .b_scale(b_scale),
    .acc_out(acc_out), .out_valid(out_valid), .overflow(overflow), .invalid(invalid)
  );

  always #10 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;

  longint q_acc[$];
  bit     q_ovf[$];
  bit     q_inv[$];
  string  q_tag[$];

  longint m_acc = 0;
  bit     m_ovf = 0;
  bit     m_inv = 0;

  localparam longint MAXV = (64'sd1 <<< 47) - 1;
  localparam longint MINV = -(64'sd1 <<< 47);

  function automatic longint e2m1_halves(logic [3:0] c);
    longint v;
    case (c[2:0])
      3'd0: v = 0;  3'd1: v = 1;  3'd2: v = 2; 3'd3: v = 3;
      3'd4: v = 4;  3'd5: v = 6;  3'd6: v = 8; default: v = 12;
    endcase
    return c[3] ? -v : v;
  endfunction

  function automatic longint e4m3_units(logic [7:0] c);
    longint v;
    int e;
    e = int'(c[6:3]);
    if (e == 0) v = longint'(c[2:0]);
    else        v = (8 + longint'(c[2:0])) * (64'sd1 <<< (e - 1));
    return c[7] ? -v : v;
  endfunction

  function automatic logic [63:0] fill(logic [3:0] c);
    return {16{c}};
  endfunction

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic send(logic [63:0] a, logic [63:0] b, logic [7:0] sa, logic [7:0] sb,
                      bit clr, string tag);
    longint sum_q, term, tot;
    bit nan;
    sum_q = 0;
    for (int i = 0; i < 16; i++)
      sum_q += e2m1_halves(a[4*i +: 4]) * e2m1_halves(b[4*i +: 4]);
    nan  = (&sa[6:0]) | (&sb[6:0]);
    term = nan ? 0 : sum_q * e4m3_units(sa) * e4m3_units(sb);
    if (clr) begin tot = term;         m_ovf = 0; m_inv = nan; end
    else     begin tot = m_acc + term; m_inv = m_inv | nan;   end
    if (tot > MAXV) begin tot = MAXV; m_ovf = 1; end
    if (tot < MINV) begin tot = MINV; m_ovf = 1; end
    m_acc = tot;
    q_acc.push_back(m_acc); q_ovf.push_back(m_ovf);
    q_inv.push_back(m_inv); q_tag.push_back(tag);
    a_codes = a; b_codes = b; a_scale = sa; b_scale = sb;
    acc_clear = clr; in_valid = 1'b1;
    @(posedge clk); #2;
    in_valid = 1'b0; acc_clear = 1'b0;
  endtask

  task automatic idle(int n);
    in_valid = 1'b0;
    repeat (n) @(posedge clk);
    #2;
  endtask

  // monitor: compare each update against the scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (q_acc.size() == 0) begin
        check(1'b0, "R4", "update with empty scoreboard", 1, 0);
      end else begin
        string t;
        longint ea;
        bit eo, ei;
        t = q_tag.pop_front(); ea = q_acc.pop_front();
        eo = q_ovf.pop_front(); ei = q_inv.pop_front();
        check(acc_out == ea, t, "acc_out", acc_out, ea);
        check(overflow == eo, t, "overflow", longint'(overflow), longint'(eo));
        check(invalid == ei, t, "invalid", longint'(invalid), longint'(ei));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [63:0] ra, rb;
    logic [7:0]  rsa, rsb;
    longint      held;
    rst_n = 1'b0; in_valid = 1'b0; acc_clear = 1'b0;
    a_codes = '0; b_codes = '0; a_scale = '0; b_scale = '0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    idle(3);

    // R9: reset state
    @(negedge clk);
    check(acc_out == 0, "R9", "acc_out after reset", acc_out, 0);
    check(!out_valid && !overflow && !invalid, "R9", "flags after reset",
          {out_valid, overflow, invalid}, 0);
    #2;

    // R4: latency of one pair into an idle pipeline
    send(fill(4'b0010), fill(4'b0010), 8'h38, 8'h38, 1, "R4");
    @(negedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R4", "out_valid one edge early", out_valid, 0);
    @(negedge clk);
    check(out_valid == 1'b1, "R4", "out_valid at third edge", out_valid, 1);
    check(acc_out == (longint'(16) <<< 20), "R3", "16.0 loaded", acc_out, 64'sd16 <<< 20);
    #2;

    // R1: negative zero adds nothing; all codes with a signed scale (R2)
    send(fill(4'b1000), fill(4'b0111), 8'h38, 8'h38, 0, "R1");
    send(64'hFEDCBA9876543210, 64'h0123456789ABCDEF, 8'h38, 8'hB8, 0, "R1");
    send(64'h76543210FEDCBA98, 64'h0F1E2D3C4B5A6978, 8'h3C, 8'h41, 0, "R2");
    // R2: subnormal scales
    send(fill(4'b0111), fill(4'b0111), 8'h01, 8'h07, 1, "R2");
    send(fill(4'b1011), fill(4'b0101), 8'h06, 8'h4D, 0, "R2");

    // R3: back-to-back random stream
    for (int k = 0; k < 24; k++) begin
      ra = {$urandom, $urandom}; rb = {$urandom, $urandom};
      rsa = {$urandom_range(0, 1) == 1, 4'($urandom_range(5, 9)), 3'($urandom)};
      rsb = {$urandom_range(0, 1) == 1, 4'($urandom_range(5, 9)), 3'($urandom)};
      send(ra, rb, rsa, rsb, (k == 0), "R3");
    end
    idle(4);

    // R5 / R10: clear without valid has no effect; result holds while idle
    @(negedge clk);
    held = acc_out;
    #2;
    acc_clear = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(acc_out == held, "R5", "acc_out after clear without valid", acc_out, held);
    check(acc_out == m_acc && !overflow && !invalid, "R10", "idle hold", acc_out, m_acc);
    #2;
    acc_clear = 1'b0;

    // R5: clear with valid loads
    send(fill(4'b0011), fill(4'b0100), 8'h40, 8'h30, 1, "R5");

    // R6: saturate high, stay sticky, then saturate low
    send(fill(4'b0111), fill(4'b0111), 8'h7E, 8'h7E, 1, "R6");
    send(fill(4'b0111), fill(4'b0111), 8'h7E, 8'h7E, 0, "R6");
    send(fill(4'b0111), fill(4'b0111), 8'hFE, 8'h7E, 0, "R6");
    send(fill(4'b0111), fill(4'b0111), 8'hFE, 8'h7E, 0, "R6");
    send(fill(4'b1111), fill(4'b0111), 8'h7E, 8'h7E, 0, "R6");
    // R8: clear-load drops the overflow flag
    send(fill(4'b0010), fill(4'b0001), 8'h38, 8'h38, 1, "R8");

    // R7: invalid scale contributes nothing and sets a sticky flag
    send(fill(4'b0010), fill(4'b0010), 8'h7F, 8'h38, 0, "R7");
    send(fill(4'b0010), fill(4'b0010), 8'h38, 8'h38, 0, "R7");
    send(fill(4'b0110), fill(4'b0010), 8'h38, 8'hFF, 1, "R7");
    // R8: clear-load drops the invalid flag
    send(fill(4'b0101), fill(4'b1010), 8'h39, 8'h38, 1, "R8");
    idle(6);

    check(q_acc.size() == 0, "R4", "scoreboard drained", q_acc.size(), 0);
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule